// File: doc/BRIEF.md
# Paged Address Translator with Translation Cache

This block turns 16-bit virtual addresses into 15-bit physical addresses for a machine with 1024-byte pages and 32 KB of physical memory. The lower ten bits of the address are the byte offset inside a page and pass through unchanged. The upper six bits name a virtual page, which is replaced by a five-bit frame number. Recent page-to-frame mappings are held in a small, fully associative cache. When a request hits in the cache, it completes in one cycle and does not touch memory.

When a request misses, the block fetches the page table entry from a base address register plus the page number, using a simple read port. It waits for the read data to come back. If the entry marks the page as present, the mapping is written into the cache and the translation completes. If the page is not present, the block reports a page fault and returns no address.

Cached entries track a modified flag. Requests are presented with a valid/ready handshake, and each one produces exactly one response pulse.

Top module: `page_xlate_top`

## Requirements
- R1: A successful response carries rsp_paddr = {frame, vaddr[9:0]}, where the frame is the 5-bit number mapped for page vaddr[15:10].
- R2: A request that hits in the cache gives rsp_valid in the cycle after it is accepted, and issues no memory read.
- R3: A request that misses raises mem_rd_en for exactly one cycle, in the cycle after acceptance, with mem_rd_addr = ptbr + vaddr[15:10] (modulo 2^16).
- R4: A page table entry is 8 bits: bits [4:0] hold the frame, bit 5 the present flag, bit 6 the modified flag and bit 7 the referenced flag.
- R5: For a present entry, the response appears in the cycle after mem_rd_valid, and the mapping is cached, so a later request to that page hits.
- R6: For an entry whose present bit is 0, the response has rsp_fault = 1 and rsp_paddr = 0, and nothing is cached, so a repeated request reads memory again.
- R7: req_ready is low from the cycle after a missing request is accepted until its response is given; otherwise it is high.
- R8: The cache holds 4 mappings. Fills go to entries in round-robin order, starting at entry 0 after reset or flush, and a fill overwrites whatever mapping that entry held.
- R9: A one-cycle pulse on flush invalidates every cached mapping and returns the fill pointer to entry 0.
- R10: Every successful translation marks the page referenced. rsp_was_ref reports whether the page was already referenced before the access: this is the entry's bit 7 on a miss, and always 1 on a hit.
- R11: A write request sets the modified flag of the cached mapping. rsp_dirty reports the flag after the access: the entry's bit 6 OR write on a miss, and the cached flag OR write on a hit.
- R12: During and right after reset, req_ready = 1, rsp_valid = 0, mem_rd_en = 0 and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all cached mappings |
| ptbr | input | 16 | Base address of the page table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 16 | Virtual address |
| req_write | input | 1 | Request is a store access |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 15 | Physical address (zero on fault) |
| rsp_fault | output | 1 | Page not present |
| rsp_dirty | output | 1 | Modified flag after this access |
| rsp_was_ref | output | 1 | Page was referenced before this access |
| mem_rd_en | output | 1 | Page table read request |
| mem_rd_addr | output | 16 | Page table entry address |
| mem_rd_valid | input | 1 | Read data is valid |
| mem_rd_data | input | 8 | Page table entry |

## Verification
The assertions check these properties on every cycle:
- The memory read strobe is a single-cycle pulse that only follows an accepted request.
- A fault never carries an address.
- The handshake drops after a miss is accepted.
- At most one cached mapping matches any page.
- Nothing hits right after a flush.

Only the bench scenarios can show the behaviours that depend on history:
- The hit and miss latencies.
- The exact table address fetched.
- The frame and offset that are returned.
- The round-robin eviction order.
- The modified and referenced flags as they evolve across repeated accesses.
- A faulting page being fetched again.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int DEF_VA_W    = 16;
  localparam int DEF_PA_W    = 15;
  localparam int DEF_OFF_W   = 10;
  localparam int DEF_DEPTH   = 4;
  localparam int DEF_MADDR_W = 16;

  typedef enum logic {
    WK_IDLE = 1'b0,
    WK_WAIT = 1'b1
  } walk_state_e;
endpackage

// File: rtl/xlate_tlb.sv
module xlate_tlb #(
  parameter int DEPTH   = 4,
  parameter int PAGE_W  = 6,
  parameter int FRAME_W = 5,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic [PAGE_W-1:0]  lk_page,
  output logic               lk_hit,
  output logic [IDX_W-1:0]   lk_idx,
  output logic [FRAME_W-1:0] lk_frame,
  output logic               lk_dirty,
  input  logic               upd_en,
  input  logic [IDX_W-1:0]   upd_idx,
  input  logic               fill_en,
  input  logic [PAGE_W-1:0]  fill_page,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic               fill_dirty
);
  logic               ent_valid [DEPTH];
  logic               ent_dirty [DEPTH];
  logic [PAGE_W-1:0]  ent_page  [DEPTH];
  logic [FRAME_W-1:0] ent_frame [DEPTH];
  logic [DEPTH-1:0]   match;
  logic [IDX_W-1:0]   rr_ptr;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign match[g] = ent_valid[g] && (ent_page[g] == lk_page);

    always_ff @(posedge clk) begin
      if (rst || flush) begin
        ent_valid[g] <= 1'b0;
        ent_dirty[g] <= 1'b0;
        ent_page[g]  <= '0;
        ent_frame[g] <= '0;
      end else if (fill_en && rr_ptr == IDX_W'(g)) begin
        ent_valid[g] <= 1'b1;
        ent_dirty[g] <= fill_dirty;
        ent_page[g]  <= fill_page;
        ent_frame[g] <= fill_frame;
      end else if (upd_en && upd_idx == IDX_W'(g)) begin
        ent_dirty[g] <= 1'b1;
      end
    end
  end

  always_comb begin
    lk_idx   = '0;
    lk_frame = '0;
    lk_dirty = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i]) begin
        lk_idx   = IDX_W'(i);
        lk_frame = ent_frame[i];
        lk_dirty = ent_dirty[i];
      end
    end
  end
  assign lk_hit = |match;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rr_ptr <= '0;
    end else if (fill_en) begin
      if (rr_ptr == IDX_W'(DEPTH - 1)) rr_ptr <= '0;
      else                             rr_ptr <= rr_ptr + 1'b1;
    end
  end

  // R8
  one_match_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(match));
  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (rst) flush |=> !lk_hit);
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker #(
  parameter int PAGE_W  = 6,
  parameter int MADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [PAGE_W-1:0]  page,
  input  logic [MADDR_W-1:0] ptbr,
  input  logic               mem_rd_valid,
  output logic               busy,
  output logic               done,
  output logic               mem_rd_en,
  output logic [MADDR_W-1:0] mem_rd_addr
);
  import xlate_pkg::*;
  walk_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= WK_IDLE;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      case (state)
        WK_IDLE: if (start) begin
          state       <= WK_WAIT;
          mem_rd_en   <= 1'b1;
          mem_rd_addr <= ptbr + MADDR_W'(page);
        end
        WK_WAIT: if (mem_rd_valid) state <= WK_IDLE;
        default: state <= WK_IDLE;
      endcase
    end
  end

  assign busy = (state != WK_IDLE);
  assign done = (state == WK_WAIT) && mem_rd_valid;

  // R3
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst) mem_rd_en |=> !mem_rd_en);
endmodule

// File: rtl/page_xlate_top.sv
module page_xlate_top #(
  parameter int VA_W    = xlate_pkg::DEF_VA_W,
  parameter int PA_W    = xlate_pkg::DEF_PA_W,
  parameter int OFF_W   = xlate_pkg::DEF_OFF_W,
  parameter int DEPTH   = xlate_pkg::DEF_DEPTH,
  parameter int MADDR_W = xlate_pkg::DEF_MADDR_W,
  localparam int PAGE_W  = VA_W - OFF_W,
  localparam int FRAME_W = PA_W - OFF_W,
  localparam int PTE_W   = FRAME_W + 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic [MADDR_W-1:0] ptbr,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               req_write,
  output logic               rsp_valid,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic               rsp_fault,
  output logic               rsp_dirty,
  output logic               rsp_was_ref,
  output logic               mem_rd_en,
  output logic [MADDR_W-1:0] mem_rd_addr,
  input  logic               mem_rd_valid,
  input  logic [PTE_W-1:0]   mem_rd_data
);
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int RES_BIT = FRAME_W;
  localparam int MOD_BIT = FRAME_W + 1;
  localparam int REF_BIT = FRAME_W + 2;

  logic               accept, busy, done;
  logic               lk_hit, lk_dirty;
  logic [IDX_W-1:0]   lk_idx;
  logic [FRAME_W-1:0] lk_frame;
  logic [PAGE_W-1:0]  req_page, pend_page;
  logic [OFF_W-1:0]   req_off, pend_off;
  logic               pend_write;
  logic               pte_res, pte_mod, pte_ref;
  logic [FRAME_W-1:0] pte_frame;
  logic               fill_en;

  assign req_page  = req_vaddr[VA_W-1:OFF_W];
  assign req_off   = req_vaddr[OFF_W-1:0];
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign pte_frame = mem_rd_data[FRAME_W-1:0];
  assign pte_res   = mem_rd_data[RES_BIT];
  assign pte_mod   = mem_rd_data[MOD_BIT];
  assign pte_ref   = mem_rd_data[REF_BIT];
  assign fill_en   = done && pte_res;

  xlate_tlb #(.DEPTH(DEPTH), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) tlb_i (
    .clk(clk), .rst(rst), .flush(flush),
    .lk_page(req_page), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .lk_frame(lk_frame), .lk_dirty(lk_dirty),
    .upd_en(accept && lk_hit && req_write), .upd_idx(lk_idx),
    .fill_en(fill_en), .fill_page(pend_page), .fill_frame(pte_frame),
    .fill_dirty(pte_mod || pend_write)
  );

  xlate_walker #(.PAGE_W(PAGE_W), .MADDR_W(MADDR_W)) walk_i (
    .clk(clk), .rst(rst), .start(accept && !lk_hit), .page(req_page),
    .ptbr(ptbr), .mem_rd_valid(mem_rd_valid), .busy(busy), .done(done),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_page  <= '0;
      pend_off   <= '0;
      pend_write <= 1'b0;
    end else if (accept && !lk_hit) begin
      pend_page  <= req_page;
      pend_off   <= req_off;
      pend_write <= req_write;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_paddr   <= '0;
      rsp_fault   <= 1'b0;
      rsp_dirty   <= 1'b0;
      rsp_was_ref <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      if (accept && lk_hit) begin
        rsp_valid   <= 1'b1;
        rsp_paddr   <= {lk_frame, req_off};
        rsp_dirty   <= lk_dirty || req_write;
        rsp_was_ref <= 1'b1;
      end else if (done) begin
        rsp_valid <= 1'b1;
        if (pte_res) begin
          rsp_paddr   <= {pte_frame, pend_off};
          rsp_dirty   <= pte_mod || pend_write;
          rsp_was_ref <= pte_ref;
        end else begin
          rsp_fault   <= 1'b1;
          rsp_paddr   <= '0;
          rsp_dirty   <= 1'b0;
          rsp_was_ref <= 1'b0;
        end
      end
    end
  end

  // R6
  fault_no_addr_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_valid && rsp_paddr == '0));
  // R3
  read_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> $past(req_valid && req_ready));
  // R7
  miss_stalls_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !lk_hit) |=> !req_ready);
endmodule

// File: tb/page_xlate_top_tb_top.sv
`timescale 1ns/1ps
module page_xlate_top_tb_top;
  logic        clk = 1'b0;
  logic        rst, flush, req_valid, req_write;
  logic [15:0] ptbr, req_vaddr;
  logic        req_ready, rsp_valid, rsp_fault, rsp_dirty, rsp_was_ref;
  logic [14:0] rsp_paddr;
  logic        mem_rd_en, mem_rd_valid;
  logic [15:0] mem_rd_addr;
  logic [7:0]  mem_rd_data;

  logic [7:0]  pt_mem [256];
  int          rd_count;
  logic [15:0] last_rd_addr;
  int          n_chk = 0, n_fail = 0;

  int          t_lat;
  logic [14:0] t_pa;
  logic        t_flt, t_dty, t_ref, t_rdylo;

  always #2.5 clk = ~clk;

  page_xlate_top dut_i (
    .clk(clk), .rst(rst), .flush(flush), .ptbr(ptbr),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_dirty(rsp_dirty), .rsp_was_ref(rsp_was_ref),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  always @(posedge clk) begin
    if (rst) begin
      mem_rd_valid <= 1'b0;
      mem_rd_data  <= 8'h00;
      rd_count     <= 0;
      last_rd_addr <= 16'h0;
    end else begin
      mem_rd_valid <= mem_rd_en;
      if (mem_rd_en) begin
        mem_rd_data  <= pt_mem[mem_rd_addr[7:0]];
        rd_count     <= rd_count + 1;
        last_rd_addr <= mem_rd_addr;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [14:0] exp_pa(input int pg, input logic [9:0] off);
    return {5'(pg + 8), off};
  endfunction

  task automatic xlate(input int pg, input logic [9:0] off, input logic wr);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = {6'(pg), off};
    req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
    t_lat   = 1;
    t_rdylo = 1'b1;
    while (!rsp_valid && t_lat < 50) begin
      if (req_ready) t_rdylo = 1'b0;
      @(negedge clk);
      t_lat++;
    end
    t_pa  = rsp_paddr;
    t_flt = rsp_fault;
    t_dty = rsp_dirty;
    t_ref = rsp_was_ref;
  endtask

  task automatic pulse_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 req_ready", 32'(req_ready), 1);
    chk("R12 rsp_valid", 32'(rsp_valid), 0);
    chk("R12 mem_rd_en", 32'(mem_rd_en), 0);
  endtask

  task automatic t_miss_then_hit();
    int r0;
    r0 = rd_count;
    xlate(1, 10'h155, 1'b0);
    chk("R5 miss latency", 32'(t_lat), 3);
    chk("R3 one read", 32'(rd_count - r0), 1);
    chk("R3 read addr", 32'(last_rd_addr), 32'h41);
    chk("R1 R4 miss paddr", 32'(t_pa), 32'(exp_pa(1, 10'h155)));
    chk("R7 ready low during walk", 32'(t_rdylo), 1);
    chk("R10 was_ref on miss", 32'(t_ref), 0);
    chk("R11 clean read", 32'(t_dty), 0);
    r0 = rd_count;
    xlate(1, 10'h3FF, 1'b0);
    chk("R2 hit latency", 32'(t_lat), 1);
    chk("R2 R5 no read on hit", 32'(rd_count - r0), 0);
    chk("R1 hit paddr", 32'(t_pa), 32'(exp_pa(1, 10'h3FF)));
    chk("R10 was_ref on hit", 32'(t_ref), 1);
  endtask

  task automatic t_dirty();
    xlate(1, 10'h004, 1'b1);
    chk("R11 write hit dirty", 32'(t_dty), 1);
    xlate(1, 10'h008, 1'b0);
    chk("R11 dirty sticky", 32'(t_dty), 1);
    xlate(3, 10'h020, 1'b0);
    chk("R4 R11 pte modified bit", 32'(t_dty), 1);
    chk("R4 R10 pte referenced bit", 32'(t_ref), 1);
    xlate(4, 10'h021, 1'b1);
    chk("R11 write miss dirty", 32'(t_dty), 1);
    xlate(4, 10'h022, 1'b0);
    chk("R11 write miss cached dirty", 32'(t_dty), 1);
  endtask

  task automatic t_fault();
    int r0;
    r0 = rd_count;
    xlate(7, 10'h0AA, 1'b0);
    chk("R6 fault flag", 32'(t_flt), 1);
    chk("R6 fault paddr zero", 32'(t_pa), 0);
    chk("R6 fault latency", 32'(t_lat), 3);
    xlate(7, 10'h0AA, 1'b0);
    chk("R6 not cached refetch", 32'(rd_count - r0), 2);
    chk("R6 repeated fault", 32'(t_flt), 1);
  endtask

  task automatic t_round_robin();
    int r0;
    pulse_flush();
    for (int p = 1; p <= 5; p++) xlate(p, 10'h010, 1'b0);
    r0 = rd_count;
    xlate(2, 10'h011, 1'b0);
    chk("R8 page2 still cached", 32'(rd_count - r0), 0);
    chk("R8 page2 paddr", 32'(t_pa), 32'(exp_pa(2, 10'h011)));
    xlate(1, 10'h012, 1'b0);
    chk("R8 page1 evicted", 32'(rd_count - r0), 1);
    xlate(3, 10'h013, 1'b0);
    chk("R8 page3 kept", 32'(rd_count - r0), 1);
    xlate(2, 10'h014, 1'b0);
    chk("R8 page2 evicted by fill", 32'(rd_count - r0), 2);
  endtask

  task automatic t_flush();
    int r0;
    xlate(5, 10'h030, 1'b0);
    r0 = rd_count;
    xlate(5, 10'h031, 1'b0);
    chk("R9 cached before flush", 32'(rd_count - r0), 0);
    pulse_flush();
    xlate(5, 10'h032, 1'b0);
    chk("R9 miss after flush", 32'(rd_count - r0), 1);
    chk("R9 paddr after flush", 32'(t_pa), 32'(exp_pa(5, 10'h032)));
  endtask

  initial begin
    #500000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) pt_mem[i] = 8'h00;
    for (int p = 0; p < 64; p++)
      pt_mem[8'h40 + p] = {(p == 3), (p == 3), (p != 7), 5'(p + 8)};
    rst = 1'b1; flush = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_vaddr = 16'h0; ptbr = 16'h0040;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_miss_then_hit();
    t_dirty();
    t_fault();
    t_round_robin();
    t_flush();
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule